// File: doc/BRIEF.md
# Protected Code Read-Back and Lock Controller

This block sits beside on-chip program storage and decides what the outside world may see and do with it. During read-back for verification, each beat carries an address and the raw byte fetched from the code store. The block returns that byte after scrambling it with a 64-entry key table: each output bit is one where the code bit and the key bit agree (XNOR). It also answers signature reads from fixed locations.

Three lock bits set a cumulative protection level. Each bit is erased to one and programmed to zero. The level drives plain enables for further programming, for read-back, for table reads from external code that fetch internal bytes, and for external execution. It also drives the request to latch the external-access strap at reset.

The key table and the lock bits are registers written through a pulse-driven programming port. A key byte or a lock bit commits only after a long run of identical pulses. A main-array byte needs a short run, and its commit is passed out as a write strobe. Read-back uses valid/ready on both sides through a single register stage. A beat is taken when `vfy_valid` and `vfy_ready` are both high, and `vfy_ready` is high whenever the output register is empty or is being drained in the same cycle. A held output keeps `out_valid` and `out_data` fixed until `out_ready` is seen.

Top module: `cvl_verify_top`

## Requirements
- R1: After reset every key byte is FFh and all three lock bits are unprogrammed. The level is open (`lock_level`=0), and `prog_en`, `verify_en`, `ext_table_en` and `ext_exec_en` are 1 while `ea_latch_en` is 0. In this state a read-back returns the code byte unchanged.
- R2: With read-back enabled and `vfy_sig`=0, an accepted beat yields, one cycle later, `out_data` = ~(`vfy_code` ^ key[`vfy_addr`[5:0]]).
- R3: Only LB1 programmed gives `lock_level`=1. At this level `ext_table_en`=0, `ea_latch_en`=1 and `prog_en`=0, and pulses aimed at the main array (`prog_sel`=0) or the key table (`prog_sel`=1) are ignored. Read-back stays enabled.
- R4: LB1 and LB2 programmed with LB3 unprogrammed gives `lock_level`=2. At this level `verify_en`=0, and a non-signature beat returns FFh.
- R5: All three bits programmed gives `lock_level`=3 and `ext_exec_en`=0, on top of every restriction of level 2.
- R6: Any other lock-bit combination, such as only LB2 or only LB3 programmed, is treated as `lock_level`=3.
- R7: A beat with `vfy_sig`=1 returns 89h at address 0030h, 58h at 0031h, `DEVICE_CODE` (FBh by default) at 0060h and FFh at any other address, whatever the level.
- R8: A commit needs a run of consecutive pulses with identical `prog_sel`, `prog_addr` and `prog_data`: 5 pulses for the main array, 25 for a key byte or a lock bit. Any change restarts the count. A main commit raises `main_wr` for one cycle, with the address and data, in the cycle after the last pulse.
- R9: A key commit clears bits only: the new key byte is old AND `prog_data`. A lock commit (`prog_sel`=2) programs LB1, LB2 or LB3 for `prog_addr`[1:0] = 0, 1 or 2. Lock commits are allowed at every level, and `prog_addr`[1:0]=3 or `prog_sel`=3 is ignored.
- R10: `vfy_ready` is low exactly when `out_valid` is high and `out_ready` is low. While it is low, `out_valid` and `out_data` hold their values.
- R11: A beat accepted in the same cycle as a key or lock commit is computed from the key and level as they were before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, erases key and lock state |
| vfy_valid | input | 1 | Read-back beat offered |
| vfy_ready | output | 1 | Read-back beat can be taken |
| vfy_addr | input | ADDR_W (16) | Read-back address |
| vfy_code | input | DATA_W (8) | Raw code byte for this address |
| vfy_sig | input | 1 | Beat is a signature read |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | DATA_W (8) | Scrambled byte, signature byte or FFh |
| prog_pulse | input | 1 | One programming pulse this cycle |
| prog_sel | input | 2 | Target: 0 main array, 1 key table, 2 lock bit, 3 none |
| prog_addr | input | ADDR_W (16) | Programming address |
| prog_data | input | DATA_W (8) | Programming data |
| main_wr | output | 1 | Main-array byte commit strobe |
| main_wr_addr | output | ADDR_W (16) | Address of the committed main byte |
| main_wr_data | output | DATA_W (8) | Data of the committed main byte |
| lock_level | output | 2 | Protection level 0 (open) to 3 (sealed) |
| prog_en | output | 1 | Main and key programming allowed |
| verify_en | output | 1 | Read-back of code allowed |
| ext_table_en | output | 1 | External-code table reads may fetch internal bytes |
| ext_exec_en | output | 1 | External execution allowed |
| ea_latch_en | output | 1 | Latch the external-access strap at reset |

## Verification
A read-back beat and a key or lock commit can land on the same clock edge, and this is the collision that matters. The bench aligns a read-back of the very key byte being programmed with the 25th pulse of its burst. It does the same for the LB2 pulse that turns read-back off. It expects the pre-commit key and the pre-commit level in the result, and it expects the new state from the next beat on. A behavioural model, stepped on the same edges, judges every output on every cycle while random output back-pressure shifts where the stalls fall.

// File: rtl/cvl_pkg.sv
package cvl_pkg;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_KEY  = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_NONE = 2'd3
  } prog_sel_e;

  typedef enum logic [1:0] {
    LVL_OPEN     = 2'd0,
    LVL_NOTABLE  = 2'd1,
    LVL_NOVERIFY = 2'd2,
    LVL_SEALED   = 2'd3
  } lock_lvl_e;

  typedef struct packed {
    logic prog_en;
    logic verify_en;
    logic ext_table_en;
    logic ext_exec_en;
    logic ea_latch_en;
  } lock_perm_t;

  localparam int SIG_MFR_ADDR = 'h30;
  localparam int SIG_MFR_VAL  = 'h89;
  localparam int SIG_FAM_ADDR = 'h31;
  localparam int SIG_FAM_VAL  = 'h58;
  localparam int SIG_DEV_ADDR = 'h60;

endpackage

// File: rtl/cvl_lock_decode.sv
module cvl_lock_decode
  import cvl_pkg::*;
(
  input  logic [2:0]  lb_erased,   // bit i = 1 : LB(i+1) unprogrammed
  output lock_lvl_e   level,
  output lock_perm_t  perm
);

  always_comb begin
    unique case (lb_erased)
      3'b111:  level = LVL_OPEN;
      3'b110:  level = LVL_NOTABLE;
      3'b100:  level = LVL_NOVERIFY;
      default: level = LVL_SEALED;   // fully sealed and every undefined mix
    endcase
  end

  always_comb begin
    perm.prog_en      = (level == LVL_OPEN);
    perm.ext_table_en = (level == LVL_OPEN);
    perm.ea_latch_en  = (level != LVL_OPEN);
    perm.verify_en    = (level == LVL_OPEN) || (level == LVL_NOTABLE);
    perm.ext_exec_en  = (level != LVL_SEALED);
  end

endmodule

// File: rtl/cvl_prog_ctrl.sv
module cvl_prog_ctrl
  import cvl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int MAIN_PULSES = 5,
  parameter int SEC_PULSES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse,
  input  prog_sel_e         sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              array_open,
  output logic              main_commit,
  output logic              key_commit,
  output logic              lock_commit
);

  localparam int MAX_P = (MAIN_PULSES > SEC_PULSES) ? MAIN_PULSES : SEC_PULSES;
  localparam int CNT_W = $clog2(MAX_P + 1);
  localparam logic [CNT_W-1:0] MAIN_T = CNT_W'(MAIN_PULSES);
  localparam logic [CNT_W-1:0] SEC_T  = CNT_W'(SEC_PULSES);

  logic [CNT_W-1:0]  run_cnt;
  prog_sel_e         run_sel;
  logic [ADDR_W-1:0] run_addr;
  logic [DATA_W-1:0] run_data;

  logic             allowed, same_run, hit;
  logic [CNT_W-1:0] cnt_nx, target;

  always_comb begin
    unique case (sel)
      SEL_LOCK:         allowed = pulse && (addr[1:0] != 2'b11);
      SEL_MAIN, SEL_KEY: allowed = pulse && array_open;
      default:          allowed = 1'b0;
    endcase
    same_run = (run_cnt != '0) && (sel == run_sel) &&
               (addr == run_addr) && (data == run_data);
    cnt_nx   = same_run ? run_cnt + 1'b1 : CNT_W'(1);
    target   = (sel == SEL_MAIN) ? MAIN_T : SEC_T;
    hit      = allowed && (cnt_nx == target);
  end

  assign main_commit = hit && (sel == SEL_MAIN);
  assign key_commit  = hit && (sel == SEL_KEY);
  assign lock_commit = hit && (sel == SEL_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_sel  <= SEL_NONE;
      run_addr <= '0;
      run_data <= '0;
    end else if (allowed) begin
      run_cnt  <= hit ? '0 : cnt_nx;
      run_sel  <= sel;
      run_addr <= addr;
      run_data <= data;
    end
  end

endmodule

// File: rtl/cvl_key_array.sv
module cvl_key_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           val <= '1;
      else if (we && (widx == IDX_W'(g)))   val <= val & wdata;   // bits only clear
    end
    assign cells[g] = val;
  end

  assign rdata = cells[ridx];

endmodule

// File: rtl/cvl_verify_top.sv
module cvl_verify_top
  import cvl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          KEY_IDX_W   = 6,
  parameter int          MAIN_PULSES = 5,
  parameter int          SEC_PULSES  = 25,
  parameter logic [7:0]  DEVICE_CODE = 8'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vfy_valid,
  output logic              vfy_ready,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [DATA_W-1:0] vfy_code,
  input  logic              vfy_sig,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              prog_pulse,
  input  logic [1:0]        prog_sel,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic              main_wr,
  output logic [ADDR_W-1:0] main_wr_addr,
  output logic [DATA_W-1:0] main_wr_data,
  output logic [1:0]        lock_level,
  output logic              prog_en,
  output logic              verify_en,
  output logic              ext_table_en,
  output logic              ext_exec_en,
  output logic              ea_latch_en
);

  localparam logic [ADDR_W-1:0] A_MFR = ADDR_W'(SIG_MFR_ADDR);
  localparam logic [ADDR_W-1:0] A_FAM = ADDR_W'(SIG_FAM_ADDR);
  localparam logic [ADDR_W-1:0] A_DEV = ADDR_W'(SIG_DEV_ADDR);

  logic [2:0]        lb_erased;
  lock_lvl_e         level;
  lock_perm_t        perm;
  logic              main_commit, key_commit, lock_commit;
  logic [DATA_W-1:0] key_byte, result;
  logic              accept;

  cvl_lock_decode u_dec (
    .lb_erased (lb_erased),
    .level     (level),
    .perm      (perm)
  );

  cvl_prog_ctrl #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MAIN_PULSES (MAIN_PULSES),
    .SEC_PULSES  (SEC_PULSES)
  ) u_prog (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse       (prog_pulse),
    .sel         (prog_sel_e'(prog_sel)),
    .addr        (prog_addr),
    .data        (prog_data),
    .array_open  (perm.prog_en),
    .main_commit (main_commit),
    .key_commit  (key_commit),
    .lock_commit (lock_commit)
  );

  cvl_key_array #(
    .IDX_W  (KEY_IDX_W),
    .DATA_W (DATA_W)
  ) u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (key_commit),
    .widx  (prog_addr[KEY_IDX_W-1:0]),
    .wdata (prog_data),
    .ridx  (vfy_addr[KEY_IDX_W-1:0]),
    .rdata (key_byte)
  );

  // lock bit storage: 1 = erased
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_erased <= 3'b111;
    end else if (lock_commit) begin
      unique case (prog_addr[1:0])
        2'd0:    lb_erased[0] <= 1'b0;
        2'd1:    lb_erased[1] <= 1'b0;
        default: lb_erased[2] <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_wr      <= 1'b0;
      main_wr_addr <= '0;
      main_wr_data <= '0;
    end else begin
      main_wr <= main_commit;
      if (main_commit) begin
        main_wr_addr <= prog_addr;
        main_wr_data <= prog_data;
      end
    end
  end

  always_comb begin
    if (vfy_sig) begin
      if      (vfy_addr == A_MFR) result = DATA_W'(SIG_MFR_VAL);
      else if (vfy_addr == A_FAM) result = DATA_W'(SIG_FAM_VAL);
      else if (vfy_addr == A_DEV) result = DATA_W'(DEVICE_CODE);
      else                        result = '1;
    end else if (!perm.verify_en) begin
      result = '1;
    end else begin
      result = ~(vfy_code ^ key_byte);
    end
  end

  assign vfy_ready = !out_valid || out_ready;
  assign accept    = vfy_valid && vfy_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign lock_level   = level;
  assign prog_en      = perm.prog_en;
  assign verify_en    = perm.verify_en;
  assign ext_table_en = perm.ext_table_en;
  assign ext_exec_en  = perm.ext_exec_en;
  assign ea_latch_en  = perm.ea_latch_en;

endmodule

// File: rtl/cvl_verify_sva.sv
module cvl_verify_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vfy_valid,
  input logic              vfy_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              main_wr,
  input logic [1:0]        lock_level,
  input logic              prog_en,
  input logic              verify_en,
  input logic              ext_exec_en
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !vfy_ready);

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_valid && vfy_ready) |=> out_valid);

  assert_nomain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> !main_wr);

  assert_noverify_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !verify_en |-> (lock_level >= 2'd2));

  assert_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_exec_en |-> (!verify_en && !prog_en));

  assert_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lock_level >= $past(lock_level)));

endmodule

bind cvl_verify_top cvl_verify_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/sim_cvl_verify_top.sv
`timescale 1ns/1ps
module sim_cvl_verify_top;

  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rst_n = 1'b0;
  logic          vfy_valid = 1'b0, vfy_sig = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] vfy_addr = '0, prog_addr = '0;
  logic [DW-1:0] vfy_code = '0, prog_data = '0;
  logic          prog_pulse = 1'b0;
  logic [1:0]    prog_sel = 2'd3;
  logic          vfy_ready, out_valid, main_wr;
  logic [DW-1:0] out_data, main_wr_data;
  logic [AW-1:0] main_wr_addr;
  logic [1:0]    lock_level;
  logic          prog_en, verify_en, ext_table_en, ext_exec_en, ea_latch_en;

  cvl_verify_top u0 (.*);

  int  n_tests = 0, n_fail = 0;
  bit  rdy_force = 1'b1;
  logic [31:0] seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_key[64];
  bit m_lb[3];            // 1 = programmed
  int m_cnt, m_sel, m_addr, m_data;
  bit m_ov, m_mw;
  int m_od, m_mwa, m_mwd;

  function automatic int m_level();
    if (!m_lb[0] && !m_lb[1] && !m_lb[2]) return 0;
    if ( m_lb[0] && !m_lb[1] && !m_lb[2]) return 1;
    if ( m_lb[0] &&  m_lb[1] && !m_lb[2]) return 2;
    return 3;
  endfunction

  function automatic int m_result(int a, int c, bit s);
    if (s) begin
      if (a == 'h30) return 'h89;
      if (a == 'h31) return 'h58;
      if (a == 'h60) return 'hFB;
      return 'hFF;
    end
    if (m_level() >= 2) return 'hFF;
    return (~(c ^ m_key[a % 64])) & 'hFF;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_key[i]) m_key[i] = 'hFF;
      foreach (m_lb[i]) m_lb[i] = 1'b0;
      m_cnt = 0; m_sel = 3; m_addr = 0; m_data = 0;
      m_ov = 0; m_od = 0; m_mw = 0; m_mwa = 0; m_mwd = 0;
    end else begin
      bit ok;
      int n, tgt;
      // result first: it sees state from before any commit on this edge (R11)
      if (vfy_valid && (!m_ov || out_ready)) begin
        m_od = m_result(int'(vfy_addr), int'(vfy_code), vfy_sig);
        m_ov = 1;
      end else if (out_ready) m_ov = 0;
      m_mw = 0;
      if (prog_pulse) begin
        if (prog_sel == 2) ok = (prog_addr[1:0] != 3);
        else if (prog_sel == 3) ok = 0;
        else ok = (m_level() == 0);
        if (ok) begin
          if (m_cnt > 0 && m_sel == prog_sel && m_addr == prog_addr && m_data == prog_data)
            n = m_cnt + 1;
          else n = 1;
          m_sel = prog_sel; m_addr = prog_addr; m_data = prog_data;
          tgt = (prog_sel == 0) ? 5 : 25;
          if (n == tgt) begin
            m_cnt = 0;
            if (prog_sel == 0) begin m_mw = 1; m_mwa = prog_addr; m_mwd = prog_data; end
            else if (prog_sel == 1) m_key[prog_addr % 64] = m_key[prog_addr % 64] & prog_data;
            else m_lb[prog_addr % 4] = 1;
          end else m_cnt = n;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int lv;
      lv = m_level();
      chk("R10 vfy_ready", vfy_ready, !m_ov || out_ready);
      chk("R10 out_valid", out_valid, m_ov);
      if (m_ov) chk("R2 out_data", out_data, m_od);
      chk("R6 lock_level", lock_level, lv);
      chk("R3 prog_en", prog_en, lv == 0);
      chk("R3 ext_table_en", ext_table_en, lv == 0);
      chk("R3 ea_latch_en", ea_latch_en, lv != 0);
      chk("R4 verify_en", verify_en, lv <= 1);
      chk("R5 ext_exec_en", ext_exec_en, lv <= 2);
      chk("R8 main_wr", main_wr, m_mw);
      if (m_mw) begin
        chk("R8 main_wr_addr", main_wr_addr, m_mwa);
        chk("R8 main_wr_data", main_wr_data, m_mwd);
      end
    end
  end

  always @(posedge clk) begin
    #2 out_ready = rdy_force ? 1'b1 : ((rnd() & 3) != 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulses(input int sel, input int a, input int d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prog_pulse = 1; prog_sel = sel[1:0]; prog_addr = a[AW-1:0]; prog_data = d[DW-1:0];
    end
    @(negedge clk);
    prog_pulse = 0; prog_sel = 2'd3;
  endtask

  // pulses with a read-back beat placed on the final pulse
  task automatic pulses_vfy(input int sel, input int a, input int d, input int n,
                            input int va, input int vc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prog_pulse = 1; prog_sel = sel[1:0]; prog_addr = a[AW-1:0]; prog_data = d[DW-1:0];
      if (i == n - 1) begin
        vfy_valid = 1; vfy_sig = 0; vfy_addr = va[AW-1:0]; vfy_code = vc[DW-1:0];
      end
    end
    @(negedge clk);
    prog_pulse = 0; prog_sel = 2'd3; vfy_valid = 0;
  endtask

  // directed beat with the consumer always ready; result read one cycle later
  task automatic vq(input int a, input int c, input bit s, input int exp, input string tag);
    @(negedge clk);
    vfy_valid = 1; vfy_addr = a[AW-1:0]; vfy_code = c[DW-1:0]; vfy_sig = s;
    @(negedge clk);
    vfy_valid = 0;
    chk(tag, out_data, exp);
  endtask

  task automatic traffic(input int n);
    rdy_force = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vfy_valid = 1; vfy_addr = rnd()[AW-1:0]; vfy_code = rnd()[DW-1:0]; vfy_sig = (rnd() % 8 == 0);
      if (vfy_sig) vfy_addr = ((rnd() & 1) != 0) ? 16'h0030 : 16'h0060;
      while (!vfy_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    vfy_valid = 0;
    rdy_force = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(8ns * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 erased state
    chk("R1 level", lock_level, 0);
    chk("R1 enables", {prog_en, verify_en, ext_table_en, ext_exec_en, ea_latch_en}, 5'b11110);
    vq('h1234, 'hA5, 0, 'hA5, "R1 erased read-back");
    traffic(40);

    // R8 main commit after 5, none after 4
    pulses(0, 'h0ABC, 'h5E, 5);
    chk("R8 main strobe", main_wr, 1);
    chk("R8 main addr", main_wr_addr, 'h0ABC);
    pulses(0, 'h0ABD, 'h11, 4);
    chk("R8 four pulses no strobe", main_wr, 0);

    // R2 / R9 key programming and AND behaviour
    pulses(1, 'h1205, 'h3C, 25);
    vq('h0405, 'h96, 0, 'h55, "R2 key 3C");
    pulses(1, 'h0005, 'hF0, 25);
    vq('h0005, 'h30, 0, 'hFF, "R9 key AND");

    // R8 restart on changed data: 20 + 10 pulses never reaches 25
    pulses(1, 7, 'h11, 20);
    pulses(1, 7, 'h22, 10);
    vq(7, 'h5A, 0, 'h5A, "R8 restart no commit");

    // R9 lock address 3 ignored
    pulses(2, 3, 0, 25);
    chk("R9 lock addr3 ignored", lock_level, 0);

    // R11 key commit and read-back on the same edge
    pulses_vfy(1, 9, 'h0F, 25, 9, 'h0F);
    chk("R11 old key used", out_data, 'h0F);
    vq(9, 'h0F, 0, 'hFF, "R11 new key after");
    traffic(40);

    // R3 LB1
    pulses(2, 0, 0, 25);
    chk("R3 level", lock_level, 1);
    chk("R3 table/ea", {ext_table_en, ea_latch_en, prog_en, verify_en}, 4'b0101);
    pulses(0, 'h0100, 'h77, 5);
    chk("R3 main ignored", main_wr, 0);
    pulses(1, 5, 'h00, 25);
    vq(5, 'h30, 0, 'hFF, "R3 key programming ignored");

    // R11 + R4 LB2 with same-edge beat, then verify blocked
    pulses_vfy(2, 1, 0, 25, 5, 'h00);
    chk("R11 old level used", out_data, 'hCF);
    chk("R4 level", lock_level, 2);
    vq(5, 'h00, 0, 'hFF, "R4 verify blocked");
    // R7 signature at a locked level
    vq('h30, 0, 1, 'h89, "R7 sig 30");
    vq('h31, 0, 1, 'h58, "R7 sig 31");
    vq('h60, 0, 1, 'hFB, "R7 sig 60");
    vq('h61, 0, 1, 'hFF, "R7 sig other");
    traffic(30);

    // R5 LB3
    pulses(2, 2, 0, 25);
    chk("R5 level", lock_level, 3);
    chk("R5 ext exec", ext_exec_en, 0);

    // R6 undefined mixes, R1 after reset
    do_reset();
    @(negedge clk);
    chk("R1 level after reset", lock_level, 0);
    vq(5, 'h30, 0, 'h30, "R1 key erased again");
    pulses(2, 1, 0, 25);
    chk("R6 only LB2", lock_level, 3);
    chk("R6 only LB2 enables", {prog_en, verify_en, ext_table_en, ext_exec_en}, 4'b0000);
    do_reset();
    pulses(2, 2, 0, 25);
    chk("R6 only LB3", lock_level, 3);
    traffic(30);

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule